// File: doc/BRIEF.md
# Virtual Address Translation and Fault Checker

This block turns one memory request per cycle into either a physical address or a fault. A request names a virtual address, an access size, whether it is a load, a store or an instruction fetch, and four qualifiers: physical addressing, privileged-firmware program counter, alternate-mode override and page-table-entry fetch. The block also receives the current privilege mode, the alternate privilege mode and the result of a translation-buffer lookup that the surrounding logic performs in the same cycle: hit, page frame number, per-mode read and write enables, and fault-on-read and fault-on-write bits.

Data accesses pass through an ordered chain of checks: size alignment, address canonical form, a kernel-only direct-mapped window, translation-buffer miss, per-mode permission, and then fault-on-access bits. Every successful address is tested against the implemented physical width and for the uncacheable I/O space, which strips a field of address bits and marks the access as uncacheable and strictly ordered. The result is registered and appears one cycle after the request, with a fault code and a status flag word that a trap handler can read.

Top module: `xlat_unit`

## Requirements
- R1: `rsp_valid` is low in reset and otherwise equals the `req_valid` of the previous cycle; all response fields come from that request. With no request the response fields read zero.
- R2: For loads and stores (`req_kind` 0 = load, 1 = store, 2 = fetch) a request whose address ANDed with (2^`req_size` - 1) is nonzero faults as misaligned (code 1) before any other check, even in physical mode; the status word then holds only the store flag (bit 0) for a store. Fetches are never checked for alignment.
- R3: For loads and stores with `req_pal` set, permission checks use `alt_mode` when `req_alt` is set and kernel mode (0) otherwise; without `req_pal` they use `cur_mode`. Fetches always use `cur_mode`. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: A translated address whose bits 63:47 are not all equal faults as an access violation (code 2); for data the status holds bad-address (bit 5) and violation (bit 1) plus the store flag, for a fetch the status is zero.
- R5: A translated address with bits 47:41 equal to 0x7E is in the direct window: if `cur_mode` is not kernel it faults as code 2 (data status: violation plus store flag; fetch status zero); otherwise the physical address is the low 44 address bits with bits 43:40 replaced by copies of bit 40.
- R6: On a translation-buffer miss a data access faults as code 5 when `req_vpte` is set and code 4 otherwise, with status miss (bit 4) plus the store flag; a fetch miss is code 4 with zero status.
- R7: On a hit the physical address is `tlb_ppn` shifted left by 13 plus the 13-bit page offset; a fetch clears the two lowest offset bits.
- R8: A store whose write-enable bit for the effective mode is clear faults as code 2 with status store, violation and, if `tlb_fonw` is set, fault-on-write (bit 3); a permitted store with `tlb_fonw` set faults as code 3 with status store and fault-on-write.
- R9: A load is checked the same way against the read enables, with fault-on-read as status bit 2 and no store flag; a fetch lacking read enable for `cur_mode` faults as code 2 with zero status, and fault-on-read does not affect fetches.
- R10: Any physical address with a bit set at position 44 or above faults as a machine check (code 6).
- R11: A physical address with bit 43 set faults as unimplemented (code 7) when bits 43:20 are all ones; otherwise `rsp_uncached` is raised and bits 42:35 are cleared, and a fetch to such an address faults as code 7.
- R12: A fetch with `req_pal` set skips all checks: the physical address is the virtual address with bits 1:0 cleared and bits 63:44 cleared, no fault, and `rsp_uncached` low.
- R13: With `req_phys` set the virtual address is used as the physical address directly, subject to R2, R10 and R11.
- R14: Any response with a nonzero fault code carries a zero physical address and a low `rsp_uncached`; code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 2 | Access size as log2 of bytes |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_phys | input | 1 | Address is already physical |
| req_pal | input | 1 | Request issued from privileged firmware |
| req_alt | input | 1 | Use alternate mode for firmware data access |
| req_vpte | input | 1 | Access is a page-table-entry fetch |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Page frame number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode, indexed by mode |
| tlb_wr_en | input | 4 | Write enable per mode, indexed by mode |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 6 | Status flag word |
| rsp_uncached | output | 1 | Uncacheable and strictly ordered |

## Verification
Several faults can be true of one request in the same cycle, and only the first in the chain may be reported: a misaligned store into the kernel-only window from user mode must report misalignment, and a store denied by its write enable on a page that also faults on write must report a violation whose status carries both flags. The vector table provokes these overlaps on purpose, with inputs chosen so that each lower-priority condition would produce a different code or status, so the reported pair shows which check won. The uncacheable space and the machine check likewise meet the window mapping and physical mode in single vectors, and each result is compared with a value worked out by hand from the requirements.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int MODE_W = 2;
    localparam int NMODE  = 1 << MODE_W;
    localparam int STAT_W = 6;

    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_PAGE     = 3'd3,
        FLT_MISS     = 3'd4,
        FLT_PTE_MISS = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMP    = 3'd7
    } flt_code_e;

    typedef enum logic [1:0] {
        PATH_TLB    = 2'd0,
        PATH_DIRECT = 2'd1,
        PATH_BYPASS = 2'd2,
        PATH_FAULT  = 2'd3
    } path_e;

    typedef struct packed {
        flt_code_e         code;
        logic [STAT_W-1:0] stat;
    } flt_t;

    function automatic flt_t no_flt();
        flt_t f;
        f.code = FLT_NONE;
        f.stat = '0;
        return f;
    endfunction

    function automatic flt_t mk_flt(flt_code_e c, logic [STAT_W-1:0] s);
        flt_t f;
        f.code = c;
        f.stat = s;
        return f;
    endfunction

    function automatic logic [STAT_W-1:0] st_bit(int pos, logic on);
        logic [STAT_W-1:0] s;
        s = '0;
        s[pos] = on;
        return s;
    endfunction

endpackage

// File: rtl/xlat_route.sv
module xlat_route
    import xlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL_W = 48,
    parameter int PA_W      = 44,
    parameter int WIN_W     = 7,
    parameter logic [WIN_W-1:0] WIN_TAG = 7'h7E
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      size_log2,
    input  acc_kind_e       kind,
    input  logic            phys,
    input  logic            pal,
    input  logic            alt_flag,
    input  cpu_mode_e       cur_mode,
    input  cpu_mode_e       alt_mode,
    output cpu_mode_e       eff_mode,
    output path_e           path,
    output flt_t            early,
    output logic [VA_W-1:0] direct_pa
);
    localparam int WIN_LO   = VA_IMPL_W - WIN_W;
    localparam int SIGN_BIT = WIN_LO - 1;
    localparam int EXT_W    = PA_W - SIGN_BIT;

    logic              is_data;
    logic              is_wr;
    logic [3:0]        size_mask;
    logic              misaligned;
    logic              canonical;
    logic              in_window;
    logic [PA_W-1:0]   win_pa;
    logic [PA_W-1:0]   pal_pa;

    always_comb begin
        is_data    = (kind != ACC_FETCH);
        is_wr      = (kind == ACC_WRITE);
        size_mask  = (4'd1 << size_log2) - 4'd1;
        misaligned = |(vaddr[3:0] & size_mask);
        canonical  = (&vaddr[VA_W-1:VA_IMPL_W-1]) | ~(|vaddr[VA_W-1:VA_IMPL_W-1]);
        in_window  = (vaddr[VA_IMPL_W-1:WIN_LO] == WIN_TAG);

        win_pa = vaddr[PA_W-1:0];
        win_pa[PA_W-1:SIGN_BIT] = {EXT_W{vaddr[SIGN_BIT]}};

        pal_pa = {vaddr[PA_W-1:2], 2'b00};

        if (is_data && pal)
            eff_mode = alt_flag ? alt_mode : MODE_KERN;
        else
            eff_mode = cur_mode;
    end

    always_comb begin
        path      = PATH_TLB;
        early     = no_flt();
        direct_pa = '0;
        if (is_data && misaligned) begin
            path  = PATH_FAULT;
            early = mk_flt(FLT_ALIGN, st_bit(ST_WR, is_wr));
        end else if (!is_data && pal) begin
            path      = PATH_BYPASS;
            direct_pa = {{(VA_W-PA_W){1'b0}}, pal_pa};
        end else if (phys) begin
            path      = PATH_DIRECT;
            direct_pa = vaddr;
        end else if (!canonical) begin
            path  = PATH_FAULT;
            early = mk_flt(FLT_ACV, is_data ? (st_bit(ST_WR, is_wr) | st_bit(ST_ACV, 1'b1)
                                               | st_bit(ST_BADVA, 1'b1)) : '0);
        end else if (in_window) begin
            if (cur_mode != MODE_KERN) begin
                path  = PATH_FAULT;
                early = mk_flt(FLT_ACV, is_data ? (st_bit(ST_WR, is_wr) | st_bit(ST_ACV, 1'b1))
                                                : '0);
            end else begin
                path      = PATH_DIRECT;
                direct_pa = {{(VA_W-PA_W){1'b0}}, win_pa};
            end
        end
    end

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PPN_W      = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [PAGE_SHIFT-1:0] offset,
    input  acc_kind_e             kind,
    input  logic                  vpte,
    input  cpu_mode_e             mode,
    input  logic                  hit,
    input  logic [PPN_W-1:0]      ppn,
    input  logic [NMODE-1:0]      rd_en,
    input  logic [NMODE-1:0]      wr_en,
    input  logic                  fonr,
    input  logic                  fonw,
    output flt_t                  flt,
    output logic [VA_W-1:0]       pa
);
    localparam int PAD_W = VA_W - PPN_W - PAGE_SHIFT;

    logic                  is_fetch;
    logic                  is_wr;
    logic [PAGE_SHIFT-1:0] offs_eff;
    logic                  may_rd;
    logic                  may_wr;

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        is_wr    = (kind == ACC_WRITE);
        offs_eff = offset;
        if (is_fetch)
            offs_eff[1:0] = 2'b00;
        pa     = {{PAD_W{1'b0}}, ppn, offs_eff};
        may_rd = rd_en[mode];
        may_wr = wr_en[mode];
    end

    always_comb begin
        flt = no_flt();
        if (!hit) begin
            if (is_fetch)
                flt = mk_flt(FLT_MISS, '0);
            else
                flt = mk_flt(vpte ? FLT_PTE_MISS : FLT_MISS,
                             st_bit(ST_WR, is_wr) | st_bit(ST_MISS, 1'b1));
        end else if (is_fetch) begin
            if (!may_rd)
                flt = mk_flt(FLT_ACV, '0);
        end else if (is_wr) begin
            if (!may_wr)
                flt = mk_flt(FLT_ACV, st_bit(ST_WR, 1'b1) | st_bit(ST_ACV, 1'b1)
                                      | st_bit(ST_FONW, fonw));
            else if (fonw)
                flt = mk_flt(FLT_PAGE, st_bit(ST_WR, 1'b1) | st_bit(ST_FONW, 1'b1));
        end else begin
            if (!may_rd)
                flt = mk_flt(FLT_ACV, st_bit(ST_ACV, 1'b1) | st_bit(ST_FONR, fonr));
            else if (fonr)
                flt = mk_flt(FLT_PAGE, st_bit(ST_FONR, 1'b1));
        end
    end

endmodule

// File: rtl/xlat_pcheck.sv
module xlat_pcheck
    import xlat_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 44,
    parameter int UNC_LO = 35,
    parameter int REG_LO = 20
) (
    input  logic [VA_W-1:0] pa_in,
    input  logic            is_fetch,
    output flt_t            flt,
    output logic [PA_W-1:0] pa_out,
    output logic            uncached
);
    localparam int UNC_HI = PA_W - 2;

    always_comb begin
        flt      = no_flt();
        pa_out   = pa_in[PA_W-1:0];
        uncached = 1'b0;
        if (|pa_in[VA_W-1:PA_W]) begin
            flt = mk_flt(FLT_MCHK, '0);
        end else if (pa_in[PA_W-1]) begin
            if (&pa_in[PA_W-1:REG_LO]) begin
                flt = mk_flt(FLT_UNIMP, '0);
            end else begin
                uncached               = 1'b1;
                pa_out[UNC_HI:UNC_LO]  = '0;
                if (is_fetch)
                    flt = mk_flt(FLT_UNIMP, '0);
            end
        end
    end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL_W  = 48,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32,
    parameter int UNC_LO     = 35,
    parameter int REG_LO     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_kind,
    input  logic              req_phys,
    input  logic              req_pal,
    input  logic              req_alt,
    input  logic              req_vpte,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [NMODE-1:0]  tlb_rd_en,
    input  logic [NMODE-1:0]  tlb_wr_en,
    input  logic              tlb_fonr,
    input  logic              tlb_fonw,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [2:0]        rsp_fault,
    output logic [STAT_W-1:0] rsp_status,
    output logic              rsp_uncached
);
    localparam int UNC_HI = PA_W - 2;

    acc_kind_e       kind;
    cpu_mode_e       eff_mode;
    path_e           path;
    flt_t            early_flt;
    flt_t            perm_flt;
    flt_t            post_flt;
    flt_t            fin_flt;
    logic [VA_W-1:0] direct_pa;
    logic [VA_W-1:0] tlb_pa;
    logic [VA_W-1:0] post_in;
    logic [PA_W-1:0] post_pa;
    logic            post_unc;
    logic [PA_W-1:0] fin_pa;
    logic            fin_unc;

    assign kind = acc_kind_e'(req_kind);

    xlat_route #(
        .VA_W      (VA_W),
        .VA_IMPL_W (VA_IMPL_W),
        .PA_W      (PA_W)
    ) u_route (
        .vaddr     (req_vaddr),
        .size_log2 (req_size),
        .kind      (kind),
        .phys      (req_phys),
        .pal       (req_pal),
        .alt_flag  (req_alt),
        .cur_mode  (cpu_mode_e'(cur_mode)),
        .alt_mode  (cpu_mode_e'(alt_mode)),
        .eff_mode  (eff_mode),
        .path      (path),
        .early     (early_flt),
        .direct_pa (direct_pa)
    );

    xlat_perm #(
        .VA_W       (VA_W),
        .PPN_W      (PPN_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_perm (
        .offset (req_vaddr[PAGE_SHIFT-1:0]),
        .kind   (kind),
        .vpte   (req_vpte),
        .mode   (eff_mode),
        .hit    (tlb_hit),
        .ppn    (tlb_ppn),
        .rd_en  (tlb_rd_en),
        .wr_en  (tlb_wr_en),
        .fonr   (tlb_fonr),
        .fonw   (tlb_fonw),
        .flt    (perm_flt),
        .pa     (tlb_pa)
    );

    assign post_in = (path == PATH_TLB) ? tlb_pa : direct_pa;

    xlat_pcheck #(
        .VA_W   (VA_W),
        .PA_W   (PA_W),
        .UNC_LO (UNC_LO),
        .REG_LO (REG_LO)
    ) u_pcheck (
        .pa_in    (post_in),
        .is_fetch (kind == ACC_FETCH),
        .flt      (post_flt),
        .pa_out   (post_pa),
        .uncached (post_unc)
    );

    always_comb begin
        fin_flt = no_flt();
        fin_pa  = '0;
        fin_unc = 1'b0;
        unique case (path)
            PATH_FAULT: fin_flt = early_flt;
            PATH_BYPASS: fin_pa = direct_pa[PA_W-1:0];
            PATH_DIRECT: begin
                fin_flt = post_flt;
                fin_pa  = post_pa;
                fin_unc = post_unc;
            end
            default: begin
                if (perm_flt.code != FLT_NONE) begin
                    fin_flt = perm_flt;
                end else begin
                    fin_flt = post_flt;
                    fin_pa  = post_pa;
                    fin_unc = post_unc;
                end
            end
        endcase
        if (fin_flt.code != FLT_NONE) begin
            fin_pa  = '0;
            fin_unc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_fault    <= '0;
            rsp_status   <= '0;
            rsp_uncached <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_paddr    <= req_valid ? fin_pa : '0;
            rsp_fault    <= req_valid ? fin_flt.code : FLT_NONE;
            rsp_status   <= req_valid ? fin_flt.stat : '0;
            rsp_uncached <= req_valid & fin_unc;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1

    AST_FAULT_CLEARS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncached)); // R14

    AST_UNCACHED_FIELD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_uncached) |-> (rsp_paddr[UNC_HI:UNC_LO] == '0 && rsp_paddr[PA_W-1])); // R11

    AST_FETCH_NO_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2) |=> (rsp_fault != 3'd1)); // R2

    AST_PAL_FETCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && req_pal)
            |=> (rsp_fault == 3'd0 && !rsp_uncached && rsp_paddr[1:0] == 2'b00)); // R12

endmodule

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 30;
    localparam int WDOG_LIM   = 20000;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  sz;
        logic [1:0]  kind;
        logic        phys;
        logic        pal;
        logic        alt;
        logic        vpte;
        logic [1:0]  cur;
        logic [1:0]  altm;
        logic        hit;
        logic [31:0] ppn;
        logic [3:0]  rd;
        logic [3:0]  wr;
        logic        fr;
        logic        fw;
        logic [2:0]  ef;
        logic [5:0]  es;
        logic [43:0] ep;
        logic        eu;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_size;
    logic [1:0]  req_kind;
    logic        req_phys, req_pal, req_alt, req_vpte;
    logic [1:0]  cur_mode, alt_mode;
    logic        tlb_hit;
    logic [31:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        tlb_fonr, tlb_fonw;
    logic        rsp_valid;
    logic [43:0] rsp_paddr;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_status;
    logic        rsp_uncached;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_size(req_size), .req_kind(req_kind), .req_phys(req_phys),
        .req_pal(req_pal), .req_alt(req_alt), .req_vpte(req_vpte),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rsp_uncached(rsp_uncached)
    );

    // Status bits: 0 store, 1 violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad address
    function automatic vec_t vec_at(int i);
        vec_t v;
        v = '0;
        v.rd = 4'hF;
        v.wr = 4'hF;
        case (i)
            0:  begin v.va = 64'h12344; v.sz = 2'd3; v.ef = 3'd1; end
            1:  begin v.va = 64'hFFFF_FC00_0000_0002; v.sz = 2'd2; v.kind = 2'd1; v.cur = 2'd3;
                      v.ef = 3'd1; v.es = 6'h01; end
            2:  begin v.va = 64'hFFFF_FC00_0000_1000; v.sz = 2'd3; v.ep = 44'h1000; end
            3:  begin v.va = 64'hFFFF_FD00_1234_5678; v.ep = 44'h800_1234_5678; v.eu = 1'b1; end
            4:  begin v.va = 64'hFFFF_FC00_0000_0000; v.cur = 2'd3; v.ef = 3'd2; v.es = 6'h02; end
            5:  begin v.va = 64'hFFFF_FC00_0000_0000; v.cur = 2'd3; v.pal = 1'b1; v.hit = 1'b1;
                      v.ef = 3'd2; v.es = 6'h02; end
            6:  begin v.va = 64'h0000_8000_0000_0000; v.kind = 2'd1; v.hit = 1'b1;
                      v.ef = 3'd2; v.es = 6'h23; end
            7:  begin v.va = 64'h2000; v.ef = 3'd4; v.es = 6'h10; end
            8:  begin v.va = 64'h2000; v.kind = 2'd1; v.vpte = 1'b1; v.ef = 3'd5; v.es = 6'h11; end
            9:  begin v.va = 64'h4_6A58; v.sz = 2'd3; v.hit = 1'b1; v.ppn = 32'h155; v.ep = 44'h2A_AA58; end
            10: begin v.va = 64'h2A5F; v.sz = 2'd3; v.kind = 2'd2; v.hit = 1'b1; v.ppn = 32'h3;
                      v.cur = 2'd3; v.rd = 4'b1000; v.ep = 44'h6A5C; end
            11: begin v.va = 64'h2A5C; v.kind = 2'd2; v.hit = 1'b1; v.ppn = 32'h3; v.cur = 2'd2;
                      v.rd = 4'b0001; v.fr = 1'b1; v.ef = 3'd2; end
            12: begin v.va = 64'h3000; v.kind = 2'd1; v.hit = 1'b1; v.cur = 2'd3; v.wr = 4'b0001;
                      v.fw = 1'b1; v.ef = 3'd2; v.es = 6'h0B; end
            13: begin v.va = 64'h3000; v.kind = 2'd1; v.hit = 1'b1; v.cur = 2'd3; v.fw = 1'b1;
                      v.ef = 3'd3; v.es = 6'h09; end
            14: begin v.va = 64'h3000; v.hit = 1'b1; v.cur = 2'd2; v.rd = 4'b0011; v.fr = 1'b1;
                      v.ef = 3'd2; v.es = 6'h06; end
            15: begin v.va = 64'h3000; v.hit = 1'b1; v.cur = 2'd2; v.fr = 1'b1; v.fw = 1'b1;
                      v.ef = 3'd3; v.es = 6'h04; end
            16: begin v.va = 64'h100; v.hit = 1'b1; v.ppn = 32'h1; v.pal = 1'b1; v.alt = 1'b1;
                      v.altm = 2'd3; v.rd = 4'b0001; v.ef = 3'd2; v.es = 6'h02; end
            17: begin v.va = 64'h100; v.hit = 1'b1; v.ppn = 32'h1; v.pal = 1'b1; v.altm = 2'd3;
                      v.cur = 2'd3; v.rd = 4'b0001; v.ep = 44'h2100; end
            18: begin v.va = 64'h0; v.hit = 1'b1; v.ppn = 32'h8000_0000; v.ef = 3'd6; end
            19: begin v.va = 64'h87F_8000_0040; v.phys = 1'b1; v.ep = 44'h807_8000_0040; v.eu = 1'b1; end
            20: begin v.va = 64'hFFF_FFF0_0010; v.phys = 1'b1; v.ef = 3'd7; end
            21: begin v.va = 64'h800_0000_0040; v.phys = 1'b1; v.kind = 2'd2; v.ef = 3'd7; end
            22: begin v.va = 64'h800_0000_0007; v.pal = 1'b1; v.kind = 2'd2; v.ep = 44'h800_0000_0004; end
            23: begin v.va = 64'hFFFF_FFFF_FFFF_FFFF; v.pal = 1'b1; v.kind = 2'd2; v.cur = 2'd3;
                      v.ep = 44'hFFF_FFFF_FFFC; end
            24: begin v.va = 64'h1000_0000_0000; v.phys = 1'b1; v.ef = 3'd6; end
            25: begin v.va = 64'h1238; v.sz = 2'd3; v.kind = 2'd1; v.phys = 1'b1; v.ep = 44'h1238; end
            26: begin v.va = 64'hFFFF_FC00_0000_2004; v.kind = 2'd2; v.ep = 44'h2004; end
            27: begin v.va = 64'hFFFF_FC00_0000_2004; v.kind = 2'd2; v.cur = 2'd1; v.ef = 3'd2; end
            28: begin v.va = 64'h1001; v.sz = 2'd1; v.phys = 1'b1; v.ef = 3'd1; end
            default: begin v.va = 64'h4000; v.kind = 2'd2; v.vpte = 1'b1; v.ef = 3'd4; end
        endcase
        return v;
    endfunction

    function automatic string req_of(int i);
        case (i)
            0, 1, 28:          return "R2";
            2, 4, 5, 26, 27:   return "R5";
            6:                 return "R4";
            7, 8, 29:          return "R6";
            9, 10:             return "R7";
            12, 13:            return "R8";
            11, 14, 15:        return "R9";
            16, 17:            return "R3";
            18, 24:            return "R10";
            3, 19, 20, 21:     return "R11";
            22, 23:            return "R12";
            default:           return "R13";
        endcase
    endfunction

    task automatic apply(vec_t v);
        req_valid = 1'b1;
        req_vaddr = v.va;  req_size = v.sz;  req_kind = v.kind;
        req_phys  = v.phys; req_pal = v.pal; req_alt = v.alt; req_vpte = v.vpte;
        cur_mode  = v.cur; alt_mode = v.altm;
        tlb_hit   = v.hit; tlb_ppn = v.ppn; tlb_rd_en = v.rd; tlb_wr_en = v.wr;
        tlb_fonr  = v.fr;  tlb_fonw = v.fw;
    endtask

    task automatic check_rsp(string tag, int idx, vec_t v);
        n_checks++;
        if (!rsp_valid || rsp_fault !== v.ef || rsp_status !== v.es ||
            rsp_paddr !== v.ep || rsp_uncached !== v.eu) begin
            n_fail++;
            $display("FAIL %s vec %0d: got valid=%0b fault=%0d status=%h paddr=%h unc=%0b, expected valid=1 fault=%0d status=%h paddr=%h unc=%0b",
                     tag, idx, rsp_valid, rsp_fault, rsp_status, rsp_paddr, rsp_uncached,
                     v.ef, v.es, v.ep, v.eu);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WDOG_LIM; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: got no completion, expected completion within %0d cycles", WDOG_LIM);
            finish_run();
        end
    end

    initial begin
        vec_t v;
        rst = 1'b1;
        apply('0);
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 3'd0 || rsp_paddr !== 44'd0) begin
            n_fail++;
            $display("FAIL R1 reset: got valid=%0b fault=%0d paddr=%h, expected 0 0 0",
                     rsp_valid, rsp_fault, rsp_paddr);
        end
        rst = 1'b0;

        // Table walk, back to back
        apply(vec_at(0));
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check_rsp(req_of(i), i, vec_at(i));
            if (i + 1 < NVEC)
                apply(vec_at(i + 1));
        end

        // R1: no request gives no response and zero fields
        req_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 3'd0 || rsp_paddr !== 44'd0 || rsp_uncached !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle: got valid=%0b fault=%0d paddr=%h unc=%0b, expected 0 0 0 0",
                     rsp_valid, rsp_fault, rsp_paddr, rsp_uncached);
        end

        // R14: a fault on an otherwise uncacheable physical address reports zero address
        v = vec_at(21);
        apply(v);
        @(negedge clk);
        n_checks++;
        if (rsp_fault !== 3'd7 || rsp_paddr !== 44'd0 || rsp_uncached !== 1'b0) begin
            n_fail++;
            $display("FAIL R14 fault-clear: got fault=%0d paddr=%h unc=%0b, expected 7 0 0",
                     rsp_fault, rsp_paddr, rsp_uncached);
        end

        // R1: reset mid-stream drops the response
        rst = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset-drop: got valid=%0b, expected 0", rsp_valid);
        end
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule